// File: doc/BRIEF.md
# Power Mode and Wake-Up Controller

This block holds the clocking state of a small microcontroller. Software writes a two-bit mode request. Bit 0 asks for Idle and bit 1 asks for Power-Down. In Idle only the core clock stops. In Power-Down the PLL, the core clock and the peripheral clocks all stop. The low-frequency oscillator, and with it the interval timer, keeps running unless a configuration bit stops it. The block also drives the override states of the two bus-strobe pins and the enable of the DAC output for each mode.

Each mode has its own set of wake sources. Idle ends on any enabled interrupt. Power-Down ends only on sources that are still clocked and qualified for wake. After a wake from Power-Down, a counter model of the PLL holds a lock bit low for a programmable number of cycles while the core already runs. When the oscillator was stopped during Power-Down, a crystal start-up interval is added to that wait. Software polls the lock bit to know when the clock is accurate.

Top module: `pwr_wake_ctl`

## Requirements
- R1: After reset the mode output is 0 (0 = Normal, 1 = Idle, 2 = Power-Down) and the request bits read 0. Core, peripheral, PLL, oscillator and timer clock enables are 1, the lock bit is 1, strobe override is 0, strobe level is 0 and the DAC enable is 1.
- R2: In Normal mode, a write with only bit 0 set moves the block to Idle on the next cycle. In Idle only the core clock enable is 0, the lock bit keeps its value, and the request bits read 01.
- R3: In Normal mode, a write with bit 1 set moves the block to Power-Down, whether or not bit 0 is also set. In Power-Down the core, peripheral and PLL enables are 0 and the lock bit reads 0.
- R4: The oscillator-stop configuration bit is captured when the block enters Power-Down. If it was 0, the oscillator and timer clock enables stay 1. If it was 1, both are 0 until wake. Changing the bit during Power-Down has no effect.
- R5: Idle ends on any interrupt among the timer tick, SPI and external 0 whose enable is 1. The qualify bits do not matter in Idle. An interrupt whose enable is 0 does not wake the block.
- R6: Power-Down ends on an enabled timer tick only if the oscillator is running. It ends on an enabled SPI interrupt only when the SPI qualify bit is 1, and on an enabled external-0 interrupt only when its qualify bit is 1.
- R7: A wake event returns the block to Normal on the next cycle, and both request bits clear themselves.
- R8: The strobe override is 1 in Idle and Power-Down. The strobe level is 1 in Idle and 0 in Power-Down. The DAC enable is 0 only in Power-Down.
- R9: After a wake from Power-Down, the lock bit reads 0 for exactly LOCK_CYC cycles. If the oscillator was stopped, it reads 0 for LOCK_CYC + XTAL_CYC cycles. The core clock enable is 1 during that wait.
- R10: If a mode write arrives together with an event that would wake the block from the requested mode, the block stays in Normal and the request bits read 0.
- R11: Mode writes made while in Idle or Power-Down are ignored.
- R12: Reset asserted in any mode returns every output to its R1 value at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Write strobe for the mode request |
| mode_wdata | input | 2 | Mode request: bit 0 Idle, bit 1 Power-Down |
| osc_stop_cfg | input | 1 | Stop the oscillator during Power-Down |
| spi_wake_qual | input | 1 | Allow SPI interrupt to end Power-Down |
| ext0_wake_qual | input | 1 | Allow external interrupt 0 to end Power-Down |
| tick_irq | input | 1 | Interval timer interrupt |
| tick_ie | input | 1 | Interval timer interrupt enable |
| spi_irq | input | 1 | SPI interrupt |
| spi_ie | input | 1 | SPI interrupt enable |
| ext0_irq | input | 1 | External interrupt 0 |
| ext0_ie | input | 1 | External interrupt 0 enable |
| mode_o | output | 2 | Current mode: 0 Normal, 1 Idle, 2 Power-Down |
| mode_req | output | 2 | Request bits as seen by software |
| core_clk_en | output | 1 | Core clock gate enable |
| periph_clk_en | output | 1 | Peripheral clock gate enable |
| pll_en | output | 1 | PLL enable |
| osc_en | output | 1 | Low-frequency oscillator enable |
| tick_clk_en | output | 1 | Interval timer clock enable |
| pll_lock | output | 1 | PLL lock status for polling |
| strobe_force | output | 1 | Override bus-strobe pins |
| strobe_level | output | 1 | Level driven on strobes when overridden |
| dac_en | output | 1 | DAC output enable (0 = high impedance) |

## Verification
On every cycle the assertions check these rules: request bits clear on wake, Power-Down has priority, writes are ignored outside Normal, the oscillator setting stays frozen through Power-Down, the lock bit stays low right after a Power-Down wake, and a wake that coincides with a mode write keeps the block in Normal. Only the bench scenarios can show the exact length of the lock wait in both oscillator cases, that disabled or unqualified interrupts leave the block asleep, and the pin states in each mode. The bench shows these by comparing against a behavioural model on every cycle and by counting the lock cycles directly.

// File: rtl/pwr_wake_ctl.sv
module pwr_wake_ctl #(
  parameter int LOCK_CYC = 16,
  parameter int XTAL_CYC = 40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_wr,
  input  logic [1:0] mode_wdata,
  input  logic       osc_stop_cfg,
  input  logic       spi_wake_qual,
  input  logic       ext0_wake_qual,
  input  logic       tick_irq,
  input  logic       tick_ie,
  input  logic       spi_irq,
  input  logic       spi_ie,
  input  logic       ext0_irq,
  input  logic       ext0_ie,
  output logic [1:0] mode_o,
  output logic [1:0] mode_req,
  output logic       core_clk_en,
  output logic       periph_clk_en,
  output logic       pll_en,
  output logic       osc_en,
  output logic       tick_clk_en,
  output logic       pll_lock,
  output logic       strobe_force,
  output logic       strobe_level,
  output logic       dac_en
);
  localparam logic [1:0] M_RUN  = 2'd0;
  localparam logic [1:0] M_IDLE = 2'd1;
  localparam logic [1:0] M_PD   = 2'd2;
  localparam int CW = $clog2(LOCK_CYC + XTAL_CYC + 1);
  localparam logic [CW-1:0] SHORT_N = CW'(LOCK_CYC);
  localparam logic [CW-1:0] LONG_N  = CW'(LOCK_CYC + XTAL_CYC);

  logic [1:0]    mode_q;
  logic          osc_off_q;
  logic [CW-1:0] cnt_q;

  wire tick_hit   = tick_irq & tick_ie;
  wire spi_hit    = spi_irq & spi_ie;
  wire ext0_hit   = ext0_irq & ext0_ie;
  wire idle_wake  = tick_hit | spi_hit | ext0_hit;
  wire pd_qual    = (spi_hit & spi_wake_qual) | (ext0_hit & ext0_wake_qual);
  wire pd_wake    = pd_qual | (tick_hit & ~osc_off_q);
  wire entry_wake = mode_wdata[1] ? (pd_qual | (tick_hit & ~osc_stop_cfg)) : idle_wake;
  wire in_run     = (mode_q == M_RUN);
  wire in_idle    = (mode_q == M_IDLE);
  wire in_pd      = (mode_q == M_PD);
  wire wake       = (in_idle & idle_wake) | (in_pd & pd_wake);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= M_RUN;
      mode_req  <= 2'b00;
      osc_off_q <= 1'b0;
    end else if (in_run && mode_wr) begin
      if (mode_wdata == 2'b00 || entry_wake) begin
        mode_req <= 2'b00;
      end else begin
        mode_req <= mode_wdata;
        if (mode_wdata[1]) begin
          mode_q    <= M_PD;
          osc_off_q <= osc_stop_cfg;
        end else begin
          mode_q <= M_IDLE;
        end
      end
    end else if (wake) begin
      mode_q    <= M_RUN;
      mode_req  <= 2'b00;
      osc_off_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (in_pd && pd_wake)
      cnt_q <= osc_off_q ? LONG_N : SHORT_N;
    else if (!in_pd && cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign mode_o        = mode_q;
  assign core_clk_en   = in_run;
  assign periph_clk_en = ~in_pd;
  assign pll_en        = ~in_pd;
  assign osc_en        = ~(in_pd & osc_off_q);
  assign tick_clk_en   = osc_en;
  assign pll_lock      = ~in_pd & (cnt_q == '0);
  assign strobe_force  = ~in_run;
  assign strobe_level  = in_idle;
  assign dac_en        = ~in_pd;

  p_wake_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wake |=> (mode_o == M_RUN && mode_req == 2'b00));
  p_pd_priority_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && mode_wr && mode_wdata[1] && !entry_wake) |=> (mode_o == M_PD && !pll_en));
  p_same_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && mode_wr && mode_wdata != 2'b00 && entry_wake) |=> (mode_o == M_RUN && mode_req == 2'b00));
  p_ignore_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_run && !wake) |=> ($stable(mode_req) && $stable(mode_o)));
  p_osc_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_pd && !pd_wake) |=> $stable(osc_en));
  p_lock_wait_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_pd && pd_wake) |=> (!pll_lock && core_clk_en));
  p_lock_no_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_lock && !(in_run && mode_wr && mode_wdata[1])) |=> pll_lock);
endmodule

// File: tb/pwr_wake_ctl_bench.sv
`timescale 1ns/1ps
module pwr_wake_ctl_bench;
  localparam int LOCK_CYC = 16;
  localparam int XTAL_CYC = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_wr = 1'b0;
  logic [1:0] mode_wdata = 2'b00;
  logic osc_stop_cfg = 1'b0, spi_wake_qual = 1'b0, ext0_wake_qual = 1'b0;
  logic tick_irq = 1'b0, tick_ie = 1'b0, spi_irq = 1'b0, spi_ie = 1'b0;
  logic ext0_irq = 1'b0, ext0_ie = 1'b0;
  logic [1:0] mode_o, mode_req;
  logic core_clk_en, periph_clk_en, pll_en, osc_en, tick_clk_en, pll_lock;
  logic strobe_force, strobe_level, dac_en;

  pwr_wake_ctl #(.LOCK_CYC(LOCK_CYC), .XTAL_CYC(XTAL_CYC)) u_pwr_wake_ctl (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_wdata(mode_wdata),
    .osc_stop_cfg(osc_stop_cfg), .spi_wake_qual(spi_wake_qual), .ext0_wake_qual(ext0_wake_qual),
    .tick_irq(tick_irq), .tick_ie(tick_ie), .spi_irq(spi_irq), .spi_ie(spi_ie),
    .ext0_irq(ext0_irq), .ext0_ie(ext0_ie), .mode_o(mode_o), .mode_req(mode_req),
    .core_clk_en(core_clk_en), .periph_clk_en(periph_clk_en), .pll_en(pll_en),
    .osc_en(osc_en), .tick_clk_en(tick_clk_en), .pll_lock(pll_lock),
    .strobe_force(strobe_force), .strobe_level(strobe_level), .dac_en(dac_en));

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  string tag = "R1";

  int m_mode = 0;
  int m_req = 0;
  int m_cnt = 0;
  bit m_oscoff = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_req = 0; m_cnt = 0; m_oscoff = 0;
    end else begin
      bit iw, pw, ew, pd_req;
      int old_mode;
      old_mode = m_mode;
      iw = (tick_irq && tick_ie) || (spi_irq && spi_ie) || (ext0_irq && ext0_ie);
      pw = (spi_irq && spi_ie && spi_wake_qual) || (ext0_irq && ext0_ie && ext0_wake_qual) ||
           (tick_irq && tick_ie && !m_oscoff);
      if (old_mode == 2 && pw) m_cnt = m_oscoff ? LOCK_CYC + XTAL_CYC : LOCK_CYC;
      else if (old_mode != 2 && m_cnt > 0) m_cnt = m_cnt - 1;
      if (old_mode == 0) begin
        if (mode_wr) begin
          pd_req = mode_wdata[1];
          ew = pd_req ? ((spi_irq && spi_ie && spi_wake_qual) || (ext0_irq && ext0_ie && ext0_wake_qual) ||
                         (tick_irq && tick_ie && !osc_stop_cfg)) : iw;
          if (mode_wdata == 0 || ew) m_req = 0;
          else begin
            m_req = mode_wdata;
            m_mode = pd_req ? 2 : 1;
            if (pd_req) m_oscoff = osc_stop_cfg;
          end
        end
      end else if ((old_mode == 1 && iw) || (old_mode == 2 && pw)) begin
        m_mode = 0; m_req = 0; m_oscoff = 0;
      end
    end
  end

  function automatic logic [12:0] model_vec();
    bit osc;
    osc = !(m_mode == 2 && m_oscoff);
    return {m_mode[1:0], m_req[1:0], m_mode == 0, m_mode != 2, m_mode != 2, osc, osc,
            m_mode != 2 && m_cnt == 0, m_mode != 0, m_mode == 1, m_mode != 2};
  endfunction

  wire [12:0] dut_vec = {mode_o, mode_req, core_clk_en, periph_clk_en, pll_en, osc_en, tick_clk_en,
                         pll_lock, strobe_force, strobe_level, dac_en};

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      checks++;
      if (dut_vec !== model_vec()) begin
        fails++;
        $display("FAIL %s cycle %0d outputs actual %b expected %b", tag, cyc, dut_vec, model_vec());
      end
    end
    if (cyc == 50000) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input string t, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", t, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
  endtask

  task automatic wr(input logic [1:0] w);
    mode_wr = 1'b1; mode_wdata = w; step(1); mode_wr = 1'b0; mode_wdata = 2'b00;
  endtask

  task automatic measure_lock(input string t, input int exp);
    int n = 0;
    while (!pll_lock && n < 1000) begin
      if (!core_clk_en) n = 2000;
      n++; step(1);
    end
    chk(t, n, exp);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(2);
    tag = "R1";
    chk("R1 reset outputs", int'(dut_vec), int'(13'b00_00_11111_1001));

    tag = "R2"; tick_ie = 1; spi_ie = 0; ext0_ie = 1;
    wr(2'b01); step(2);
    chk("R2 idle mode", mode_o, 1);
    chk("R2 core off", core_clk_en, 0);
    chk("R8 idle strobes", {strobe_force, strobe_level, dac_en}, 3'b111);
    tag = "R5"; spi_irq = 1; step(1); spi_irq = 0; step(2);
    chk("R5 disabled irq keeps idle", mode_o, 1);
    tag = "R11"; wr(2'b10); step(1);
    chk("R11 write in idle ignored", mode_req, 1);
    tag = "R5"; ext0_irq = 1; step(1); ext0_irq = 0;
    chk("R5 R7 enabled irq wakes idle", {mode_o, mode_req}, 0);
    step(3);

    tag = "R3"; spi_ie = 1; spi_wake_qual = 0; osc_stop_cfg = 0; tick_ie = 0;
    wr(2'b11); step(2);
    chk("R3 power-down priority", mode_o, 2);
    chk("R3 pll and lock off", {pll_en, pll_lock, periph_clk_en}, 0);
    chk("R8 pd strobes", {strobe_force, strobe_level, dac_en}, 3'b100);
    chk("R4 osc kept", {osc_en, tick_clk_en}, 3);
    tag = "R6"; spi_irq = 1; step(1); spi_irq = 0; step(2);
    chk("R6 unqualified spi ignored", mode_o, 2);
    spi_wake_qual = 1; spi_irq = 1; step(1); spi_irq = 0;
    tag = "R9";
    chk("R7 pd wake clears", {mode_o, mode_req}, 0);
    measure_lock("R9 short lock wait", LOCK_CYC);
    step(2);

    tag = "R4"; osc_stop_cfg = 1; tick_ie = 1; ext0_wake_qual = 0;
    wr(2'b10); osc_stop_cfg = 0; step(2);
    chk("R4 osc stopped and latched", {osc_en, tick_clk_en}, 0);
    tag = "R6"; tick_irq = 1; step(1); tick_irq = 0; step(2);
    chk("R6 tick without osc ignored", mode_o, 2);
    ext0_irq = 1; step(2);
    chk("R6 unqualified ext0 ignored", mode_o, 2);
    ext0_wake_qual = 1; step(1); ext0_irq = 0;
    tag = "R9";
    measure_lock("R9 long lock wait", LOCK_CYC + XTAL_CYC);

    tag = "R6"; osc_stop_cfg = 0;
    wr(2'b10); step(2);
    tick_irq = 1; step(1); tick_irq = 0;
    chk("R6 tick with osc wakes", mode_o, 0);
    tag = "R9";
    measure_lock("R9 lock after tick wake", LOCK_CYC);

    tag = "R10"; spi_irq = 1;
    wr(2'b10);
    chk("R10 coincident wake stays normal", {mode_o, mode_req}, 0);
    spi_irq = 0; tick_irq = 1;
    wr(2'b01);
    chk("R10 coincident idle wake", {mode_o, mode_req}, 0);
    tick_irq = 0; step(2);

    tag = "R12"; osc_stop_cfg = 1;
    wr(2'b10); step(3);
    rst_n = 1'b0; #1;
    chk("R12 reset from pd", int'(dut_vec), int'(13'b00_00_11111_1001));
    step(2); rst_n = 1'b1; step(3);
    chk("R12 normal after reset", mode_o, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule